// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block maps outbound memory addresses from a local bus onto 64-bit PCIe bus addresses. The local aperture, starting at the parameter `LOCAL_BASE`, is cut into `NUM_WIN` equal windows. Each window is a power-of-two number of megabytes long, and the power is chosen by a 3-bit size index. Each window holds a 64-bit translated base, split across a low word and a high word. The low word also carries the window's own enable bit. A single global enable bit gates every window at once.

Configuration arrives on a simple write-only port made of an enable, a 12-bit byte offset and a 32-bit data word. A request is one local address qualified by `req_valid`. Exactly one cycle later the unit presents the result: a valid strobe, a hit flag, the translated address and the index of the window that was used. Software normally programs consecutive windows so that they cover one contiguous local range, stepping the base by one window size each time.

A small state machine holds the kind of result currently on the outputs:
- `ST_IDLE` means no result.
- `ST_HIT` means a translated address is on the outputs.
- `ST_MISS` means a rejected request.

Every clock the machine moves to one of three states:
- to `ST_HIT` when a request arrives and the lookup succeeds;
- to `ST_MISS` when a request arrives and the lookup fails;
- to `ST_IDLE` when no request arrives.

These transitions are the same from every state.

Top module: `owb_xlat_unit`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_hit`, `rsp_addr` and `rsp_win` are all zero. The global enable, the size index and every window word are cleared to zero, so every request misses until software programs the unit.
- R2: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high, and is low otherwise. While `rsp_valid` is low, all the other outputs are zero.
- R3: The window size is 2^k MiB. Here k is bits [2:0] of the word written to offset 0x030, and the upper bits of that word are ignored.
- R4: The window index is (req_addr - LOCAL_BASE) >> (20 + k). On a hit, `rsp_win` is that index, and `rsp_addr` is {high word, low word with bit 0 cleared} plus the address bits below 20 + k, with a full 64-bit carry.
- R5: Translation is active only while bit 1 of the word last written to offset 0x004 is 1. Other bits of that word have no effect. While bit 1 is 0, every request misses.
- R6: The low word of window n is at offset 0x200 + 8n and the high word at 0x204 + 8n. A request that selects a window whose low-word bit 0 is 0 misses.
- R7: A request whose window index is `NUM_WIN` or more misses.
- R8: A request whose address is below `LOCAL_BASE` misses.
- R9: A miss shows `rsp_valid` = 1, `rsp_hit` = 0, `rsp_addr` = 0 and `rsp_win` = 0.
- R10: A register write in cycle t is used by a request in cycle t+1. A request in the same cycle t still sees the old value.
- R11: Writes to offsets other than 0x004, 0x030 and the window words change no translation result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Byte offset of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request qualifier |
| req_addr | input | LADDR_W (32) | Local address to translate |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_addr | output | 64 | Translated bus address, zero on a miss |
| rsp_win | output | $clog2(NUM_WIN) (5) | Window index used, zero on a miss |

## Verification
Every result is due exactly one clock after the cycle in which its request is presented. A register write acts on requests from the next cycle onward. The bench drives a cycle's inputs after a falling edge. At the rising edge, its reference model first computes the expected result from the register copy it holds, and only then applies that cycle's write to the copy. The outputs are compared at the next falling edge. With this ordering, a request issued in the same cycle as a write is checked against the old register value, exactly as the timing rule requires. Idle cycles are compared as well, so a stray or late `rsp_valid` is caught in the cycle it appears.

// File: rtl/owb_pkg.sv
package owb_pkg;

    // Register offsets the window decoder and the software sequence rely on
    localparam logic [11:0] CTRL_OFS  = 12'h004;
    localparam logic [11:0] SIZE_OFS  = 12'h030;
    localparam logic [11:0] WIN_OFS   = 12'h200;
    localparam int          WIN_STEP  = 8;
    localparam int          HI_DELTA  = 4;

    // Control word field positions
    localparam int          XLAT_EN_BIT = 1;
    localparam int          WIN_EN_BIT  = 0;

    // One megabyte granule
    localparam int          MB_SHIFT  = 20;
    localparam int          SIZE_W    = 3;
    localparam int          OUT_W     = 64;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } rsp_state_t;

endpackage

// File: rtl/owb_cfg_regs.sv
module owb_cfg_regs
    import owb_pkg::*;
#(
    parameter int NUM_WIN = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [11:0]                     cfg_addr,
    input  logic [31:0]                     cfg_wdata,
    output logic                            xlat_en,
    output logic [SIZE_W-1:0]               size_idx,
    output logic [NUM_WIN-1:0][31:0]        win_lo,
    output logic [NUM_WIN-1:0][31:0]        win_hi
);

    logic ctrl_sel;
    logic size_sel;

    assign ctrl_sel = cfg_we && (cfg_addr == CTRL_OFS);
    assign size_sel = cfg_we && (cfg_addr == SIZE_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xlat_en  <= 1'b0;
            size_idx <= '0;
        end else begin
            if (ctrl_sel) begin
                xlat_en <= cfg_wdata[XLAT_EN_BIT];
            end
            if (size_sel) begin
                size_idx <= cfg_wdata[SIZE_W-1:0];
            end
        end
    end

    // One low/high word pair per window
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [11:0] LO_OFS = 12'(int'(WIN_OFS) + WIN_STEP * w);
        localparam logic [11:0] HI_OFS = 12'(int'(WIN_OFS) + WIN_STEP * w + HI_DELTA);

        logic lo_sel;
        logic hi_sel;

        assign lo_sel = cfg_we && (cfg_addr == LO_OFS);
        assign hi_sel = cfg_we && (cfg_addr == HI_OFS);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win_lo[w] <= '0;
                win_hi[w] <= '0;
            end else begin
                if (lo_sel) begin
                    win_lo[w] <= cfg_wdata;
                end
                if (hi_sel) begin
                    win_hi[w] <= cfg_wdata;
                end
            end
        end
    end

endmodule

// File: rtl/owb_win_lookup.sv
module owb_win_lookup
    import owb_pkg::*;
#(
    parameter int                     NUM_WIN    = 32,
    parameter int                     LADDR_W    = 32,
    parameter logic [LADDR_W-1:0]     LOCAL_BASE = '0
) (
    input  logic                            xlat_en,
    input  logic [SIZE_W-1:0]               size_idx,
    input  logic [NUM_WIN-1:0][31:0]        win_lo,
    input  logic [NUM_WIN-1:0][31:0]        win_hi,
    input  logic [LADDR_W-1:0]              req_addr,
    output logic                            hit,
    output logic [OUT_W-1:0]                xaddr,
    output logic [$clog2(NUM_WIN)-1:0]      win_idx
);

    localparam int WIDX_W = $clog2(NUM_WIN);

    logic               below_base;
    logic [LADDR_W-1:0] offset;
    logic [5:0]         shamt;
    logic [LADDR_W-1:0] idx_full;
    logic               in_range;
    logic [WIDX_W-1:0]  idx;
    logic [LADDR_W-1:0] in_win_mask;
    logic [31:0]        sel_lo;
    logic [31:0]        sel_hi;
    logic [OUT_W-1:0]   base;
    logic [OUT_W-1:0]   sum;

    always_comb begin
        below_base  = req_addr < LOCAL_BASE;
        offset      = req_addr - LOCAL_BASE;
        shamt       = 6'(MB_SHIFT) + {3'b000, size_idx};
        idx_full    = offset >> shamt;
        in_range    = idx_full < LADDR_W'(NUM_WIN);
        idx         = idx_full[WIDX_W-1:0];
        in_win_mask = (LADDR_W'(1) << shamt) - LADDR_W'(1);
        sel_lo      = win_lo[idx];
        sel_hi      = win_hi[idx];
        base        = {sel_hi, sel_lo[31:1], 1'b0};
        sum         = base + OUT_W'(offset & in_win_mask);
        hit         = xlat_en && !below_base && in_range && sel_lo[WIN_EN_BIT];
        xaddr       = hit ? sum : '0;
        win_idx     = hit ? idx : '0;
    end

endmodule

// File: rtl/owb_xlat_unit.sv
module owb_xlat_unit
    import owb_pkg::*;
#(
    parameter int                     NUM_WIN    = 32,
    parameter int                     LADDR_W    = 32,
    parameter logic [LADDR_W-1:0]     LOCAL_BASE = 32'h4000_0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [11:0]                   cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    input  logic                          req_valid,
    input  logic [LADDR_W-1:0]            req_addr,
    output logic                          rsp_valid,
    output logic                          rsp_hit,
    output logic [63:0]                   rsp_addr,
    output logic [$clog2(NUM_WIN)-1:0]    rsp_win
);

    localparam int WIDX_W = $clog2(NUM_WIN);

    logic                       cfg_xlat_en;
    logic [SIZE_W-1:0]          cfg_size;
    logic [NUM_WIN-1:0][31:0]   cfg_lo;
    logic [NUM_WIN-1:0][31:0]   cfg_hi;

    logic                       lk_hit;
    logic [OUT_W-1:0]           lk_addr;
    logic [WIDX_W-1:0]          lk_win;

    rsp_state_t                 state_q;
    rsp_state_t                 state_d;
    logic [OUT_W-1:0]           addr_q;
    logic [WIDX_W-1:0]          win_q;

    owb_cfg_regs #(
        .NUM_WIN (NUM_WIN)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .xlat_en   (cfg_xlat_en),
        .size_idx  (cfg_size),
        .win_lo    (cfg_lo),
        .win_hi    (cfg_hi)
    );

    owb_win_lookup #(
        .NUM_WIN    (NUM_WIN),
        .LADDR_W    (LADDR_W),
        .LOCAL_BASE (LOCAL_BASE)
    ) lookup_i (
        .xlat_en  (cfg_xlat_en),
        .size_idx (cfg_size),
        .win_lo   (cfg_lo),
        .win_hi   (cfg_hi),
        .req_addr (req_addr),
        .hit      (lk_hit),
        .xaddr    (lk_addr),
        .win_idx  (lk_win)
    );

    // Next-state: a request always produces a result state next cycle
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? (lk_hit ? ST_HIT : ST_MISS) : ST_IDLE;
            ST_HIT:  state_d = req_valid ? (lk_hit ? ST_HIT : ST_MISS) : ST_IDLE;
            ST_MISS: state_d = req_valid ? (lk_hit ? ST_HIT : ST_MISS) : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result payload captured only on a hit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            win_q  <= '0;
        end else if (req_valid && lk_hit) begin
            addr_q <= lk_addr;
            win_q  <= lk_win;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_addr  = '0;
        rsp_win   = '0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
            end
            ST_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_addr  = addr_q;
                rsp_win   = win_q;
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
            end
            default: begin
                rsp_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/owb_xlat_chk.sv
module owb_xlat_chk #(
    parameter int                     NUM_WIN    = 32,
    parameter int                     LADDR_W    = 32,
    parameter logic [LADDR_W-1:0]     LOCAL_BASE = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [LADDR_W-1:0]            req_addr,
    input  logic                          xlat_en,
    input  logic                          rsp_valid,
    input  logic                          rsp_hit,
    input  logic [63:0]                   rsp_addr,
    input  logic [$clog2(NUM_WIN)-1:0]    rsp_win
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && rsp_addr == '0 && rsp_win == '0));

    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_win == '0));

    assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlat_en) |=> !rsp_hit);

    assert_below_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr < LOCAL_BASE) |=> !rsp_hit);

endmodule

bind owb_xlat_unit owb_xlat_chk #(
    .NUM_WIN    (NUM_WIN),
    .LADDR_W    (LADDR_W),
    .LOCAL_BASE (LOCAL_BASE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .xlat_en   (cfg_xlat_en),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_addr  (rsp_addr),
    .rsp_win   (rsp_win)
);

// File: tb/owb_xlat_unit_tb_top.sv
`timescale 1ns/1ps
module owb_xlat_unit_tb_top;

    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam int          MB   = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [63:0] rsp_addr;
    logic [4:0]  rsp_win;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    bit          m_en;
    logic [2:0]  m_size;
    logic [31:0] m_lo [32];
    logic [31:0] m_hi [32];

    always #2.5 clk = ~clk;

    owb_xlat_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_addr  (rsp_addr),
        .rsp_win   (rsp_win)
    );

    function automatic void model_reset();
        m_en   = 1'b0;
        m_size = '0;
        for (int i = 0; i < 32; i++) begin
            m_lo[i] = '0;
            m_hi[i] = '0;
        end
    endfunction

    function automatic void model_expect(input logic [31:0] a, output logic h,
                                         output logic [63:0] x, output logic [4:0] w);
        logic [31:0] off;
        logic [31:0] idx;
        int          sh;
        h = 1'b0;
        x = '0;
        w = '0;
        if (!m_en || a < BASE) return;
        off = a - BASE;
        sh  = 20 + int'(m_size);
        idx = off >> sh;
        if (idx >= 32) return;
        if (!m_lo[idx][0]) return;
        h = 1'b1;
        w = idx[4:0];
        x = {m_hi[idx], m_lo[idx] & 32'hFFFF_FFFE} + 64'(off & ((32'd1 << sh) - 32'd1));
    endfunction

    function automatic void model_write(input logic [11:0] wa, input logic [31:0] wd);
        int rel;
        if (wa == 12'h004) m_en = wd[1];
        if (wa == 12'h030) m_size = wd[2:0];
        if (wa >= 12'h200 && wa < 12'h300) begin
            rel = int'(wa) - 'h200;
            if (rel % 8 == 0) m_lo[rel / 8] = wd;
            if (rel % 8 == 4) m_hi[rel / 8] = wd;
        end
    endfunction

    task automatic check_outputs(input logic ev, input logic eh, input logic [63:0] ea,
                                 input logic [4:0] ew, input string tag);
        n_vec++;
        if (rsp_valid !== ev || rsp_hit !== eh || rsp_addr !== ea || rsp_win !== ew) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b hit=%0b addr=%h win=%0d, expected valid=%0b hit=%0b addr=%h win=%0d",
                     tag, rsp_valid, rsp_hit, rsp_addr, rsp_win, ev, eh, ea, ew);
        end
    endtask

    // One clock: drive, model at the rising edge, compare at the falling edge
    task automatic cycle(input logic we, input logic [11:0] wa, input logic [31:0] wd,
                         input logic rv, input logic [31:0] ra, input string tag);
        logic        eh;
        logic [63:0] ea;
        logic [4:0]  ew;
        cfg_we    = we;
        cfg_addr  = wa;
        cfg_wdata = wd;
        req_valid = rv;
        req_addr  = ra;
        @(posedge clk);
        if (rv) begin
            model_expect(ra, eh, ea, ew);
        end else begin
            eh = 1'b0;
            ea = '0;
            ew = '0;
        end
        if (we) model_write(wa, wd);
        @(negedge clk);
        check_outputs(rv, eh, ea, ew, tag);
    endtask

    task automatic wr(input logic [11:0] wa, input logic [31:0] wd, input string tag);
        cycle(1'b1, wa, wd, 1'b0, '0, tag);
    endtask

    task automatic rq(input logic [31:0] ra, input string tag);
        cycle(1'b0, '0, '0, 1'b1, ra, tag);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, outputs quiet
        check_outputs(1'b0, 1'b0, '0, '0, "R1 reset outputs");
        rq(BASE + 32'h100, "R1 request after reset misses");
        cycle(1'b0, '0, '0, 1'b0, '0, "R2 idle cycle");

        // R3: size index 3 (8 MiB), upper bits of the word ignored
        wr(12'h030, 32'hFFFF_FFFB, "R3 size write");
        for (int n = 0; n < 4; n++) begin
            wr(12'(32'h200 + 8 * n), 32'h8000_0001 + 32'(n) * 8 * MB, "R6 window low");
            wr(12'(32'h204 + 8 * n), 32'h0000_0001 + 32'(n), "R6 window high");
        end
        wr(12'h220, 32'h9000_0000, "R6 window 4 without enable");

        // R10: enable write with a same-cycle request sees the old value
        cycle(1'b1, 12'h004, 32'h0000_0002, 1'b1, BASE + 32'h10, "R10 same-cycle old value");
        rq(BASE + 32'h10, "R10 next-cycle new value");
        rq(BASE + 32'h0012_3456, "R4 window 0");
        rq(BASE + 8 * MB + 5, "R4 window 1");
        cycle(1'b0, '0, '0, 1'b0, '0, "R2 gap");
        rq(BASE + 4 * 8 * MB - 1, "R4 window 3 top byte");
        rq(BASE + 4 * 8 * MB, "R6 R9 disabled window");
        rq(BASE - 1, "R8 R9 below base");

        // R3: 1 MiB windows; index 40 is out of range
        wr(12'h030, 32'h0000_0000, "R3 size 1 MiB");
        rq(BASE + 40 * MB, "R7 R9 index beyond last window");
        rq(BASE + 2 * MB + 7, "R3 window 2 at 1 MiB");
        // 128 MiB windows
        wr(12'h030, 32'h0000_0007, "R3 size 128 MiB");
        rq(BASE + 130 * MB, "R3 window 1 at 128 MiB");

        // R11: undecoded offsets have no effect
        wr(12'h300, 32'h0000_0000, "R11 write past last window");
        wr(12'h008, 32'hFFFF_FFFF, "R11 write other offset");
        wr(12'h201, 32'h0000_0000, "R11 write unaligned");
        rq(BASE + 130 * MB, "R11 result unchanged");

        // Last window with a carry out of the low word
        wr(12'h030, 32'h0000_0000, "R3 size 1 MiB");
        wr(12'h2F8, 32'hFFFF_FFF1, "R6 window 31 low");
        wr(12'h2FC, 32'h0000_0002, "R6 window 31 high");
        rq(BASE + 31 * MB + 32'h20, "R4 window 31 carry");

        // R5: global enable
        wr(12'h004, 32'h0000_0000, "R5 disable");
        rq(BASE + 32'h10, "R5 R9 disabled miss");
        wr(12'h004, 32'hFFFF_FFFD, "R5 other bits set");
        rq(BASE + 32'h10, "R5 bit 1 clear still off");
        wr(12'h004, 32'h0000_0002, "R5 re-enable");
        rq(BASE + 32'h10, "R5 re-enabled hit");

        // Mixed traffic with random writes
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra;
            ra = BASE - 32'h100 + ($urandom % (48 * MB));
            if (i % 37 == 0) begin
                cycle(1'b1, 12'h030, $urandom % 4, ($urandom % 2) == 1, ra, "R4 R10 random with size write");
            end else if (i % 11 == 0) begin
                cycle(1'b1, 12'(32'h200 + 8 * ($urandom % 32)), $urandom, ($urandom % 2) == 1, ra,
                      "R6 R10 random with window write");
            end else begin
                cycle(1'b0, '0, '0, ($urandom % 3) != 0, ra, "R2 R4 random traffic");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule